// File: doc/BRIEF.md
# Cascadable 32-Source Interrupt Controller

This block gathers 32 level-sensitive interrupt sources into one request line for a processor or for another controller of the same kind. Each source owns one bit of a pending register; the bit is set on any clock cycle in which its input is high. It stays set until software clears it by writing a one to it. An enable register selects which pending bits may raise the request. The controller reports two results: the AND of pending and enable, and the number of the most urgent pending, enabled source.

Numbering runs from the most significant bit downwards. Source 0 sits in bit 31, source 31 in bit 0, and a lower source number wins. When nothing is pending and enabled, the vector output reads 255. Software reaches the registers through a small word-wide bus whose write strobe is sampled on the clock edge and whose read data follows the address combinationally.

Controllers can be chained. A child's `irq_req` is a plain level, so it can drive a source input of a parent controller. In a three-controller tree the second controller feeds source 30 of the first and the third feeds source 28. To bring the block up, software writes zero to the enable register and then writes all ones to the pending register.

Top module: `cascade_irq_ctrl`

## Requirements
- R1: Source n drives `src_lvl[31-n]` and owns pending bit 31-n. A high input sets its pending bit on that clock edge, and the bit stays set after the input falls.
- R2: Offset 1 is the enable register. A write there replaces all 32 bits, and a read returns the stored value.
- R3: Offset 2 reads pending AND enable and ignores writes, which change neither register. Offset 3 reads as zero.
- R4: A write to offset 0 clears every pending bit written as one and leaves every bit written as zero unchanged. A read of offset 0 returns the pending bits.
- R5: When a source input is high in the same cycle as a write that clears its bit, the bit stays set.
- R6: `irq_req` is the OR of the masked bits and appears one clock edge after the registers change.
- R7: `irq_vec` is the lowest-numbered source that is both pending and enabled. It has the same one-edge latency as `irq_req`. Source 0 outranks every other source, and source 31 is reported when it is the only one pending.
- R8: `irq_vec` reads 255 whenever no enabled source is pending.
- R9: After reset the pending and enable registers are zero, `irq_req` is 0 and `irq_vec` is 255.
- R10: Writing zero to offset 1 and then all ones to offset 0 leaves nothing pending and drops `irq_req`, even if sources were active before.
- R11: `irq_req` stays high on every cycle while any enabled source is pending, with no self-clearing, so it can serve as a level input of a parent controller.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| src_lvl | input | 32 | Source levels; bit 31-n is source n |
| bus_we | input | 1 | Register write strobe, sampled on the clock edge |
| bus_addr | input | 2 | Register offset: 0 pending, 1 enable, 2 masked, 3 unused |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq_req | output | 1 | Request: OR of pending AND enable, registered |
| irq_vec | output | 8 | Highest-priority pending source number, or 255 if none |

## Verification
A wrong pending or enable bit shows in the `bus_rdata` of offset 0, 1 or 2 on the cycle right after the edge that stored it. It shows one edge later on `irq_req` and `irq_vec`. A fault in the priority encoder shows only as a wrong `irq_vec` while two or more enabled sources are pending, so the bench builds such sets at both ends of the bit order. A clear that loses to an active input, or a write to the read-only offset that leaks into the enable register, is visible on the very next read of the affected offset.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

  localparam int unsigned IRQC_AW = 2;
  localparam int unsigned IRQC_VW = 8;

  typedef enum logic [IRQC_AW-1:0] {
    OFS_PEND = 2'd0,
    OFS_ENA  = 2'd1,
    OFS_MSKD = 2'd2,
    OFS_RSVD = 2'd3
  } irqc_ofs_e;

  localparam logic [IRQC_VW-1:0] IRQC_NONE = 8'hFF;

endpackage

// File: rtl/irqc_rst_sync.sv
module irqc_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/irqc_regs.sv
module irqc_regs
  import irqc_pkg::*;
#(
  parameter int unsigned N_SRC = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_SRC-1:0]   src_lvl,
  input  logic               bus_we,
  input  logic [IRQC_AW-1:0] bus_addr,
  input  logic [N_SRC-1:0]   bus_wdata,
  output logic [N_SRC-1:0]   pend_q,
  output logic [N_SRC-1:0]   ena_q,
  output logic [N_SRC-1:0]   mskd,
  output logic [N_SRC-1:0]   bus_rdata
);

  logic             ack_hit;
  logic             ena_hit;
  logic [N_SRC-1:0] ack_mask;
  logic [N_SRC-1:0] pend_d;
  logic             pend_ce;
  logic [N_SRC-1:0] ena_d;
  logic             ena_ce;

  // next-state: a high level input always overrides a clear in the same cycle
  always_comb begin
    ack_hit  = bus_we && (bus_addr == OFS_PEND);
    ena_hit  = bus_we && (bus_addr == OFS_ENA);
    ack_mask = ack_hit ? bus_wdata : '0;
    pend_d   = (pend_q & ~ack_mask) | src_lvl;
    pend_ce  = ack_hit || (|(src_lvl & ~pend_q));
    ena_d    = bus_wdata;
    ena_ce   = ena_hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
    end else if (pend_ce) begin
      pend_q <= pend_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ena_q <= '0;
    end else if (ena_ce) begin
      ena_q <= ena_d;
    end
  end

  assign mskd = pend_q & ena_q;

  always_comb begin
    unique case (irqc_ofs_e'(bus_addr))
      OFS_PEND: bus_rdata = pend_q;
      OFS_ENA:  bus_rdata = ena_q;
      OFS_MSKD: bus_rdata = mskd;
      default:  bus_rdata = '0;
    endcase
  end

endmodule

// File: rtl/irqc_prio.sv
module irqc_prio #(
  parameter int unsigned N_SRC = 32,
  localparam int unsigned IW   = $clog2(N_SRC)
) (
  input  logic [N_SRC-1:0] mskd,
  output logic             any_pend,
  output logic [IW-1:0]    win_idx
);

  logic [N_SRC:0]   seen;
  logic [N_SRC-1:0] first;

  assign seen[0] = 1'b0;

  // walk from the most significant bit (source 0) downwards
  for (genvar g = 0; g < N_SRC; g++) begin : g_chain
    assign first[g]  = mskd[N_SRC-1-g] & ~seen[g];
    assign seen[g+1] = seen[g] | mskd[N_SRC-1-g];
  end

  always_comb begin
    win_idx = '0;
    for (int i = 0; i < N_SRC; i++) begin
      if (first[i]) begin
        win_idx = win_idx | IW'(i);
      end
    end
  end

  assign any_pend = seen[N_SRC];

endmodule

// File: rtl/irqc_out.sv
module irqc_out
  import irqc_pkg::*;
#(
  parameter int unsigned N_SRC = 32,
  localparam int unsigned IW   = $clog2(N_SRC)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               any_pend,
  input  logic [IW-1:0]      win_idx,
  output logic               irq_req,
  output logic [IRQC_VW-1:0] irq_vec
);

  logic               req_q;
  logic               req_d;
  logic [IRQC_VW-1:0] vec_q;
  logic [IRQC_VW-1:0] vec_d;
  logic               out_ce;

  always_comb begin
    req_d  = any_pend;
    vec_d  = any_pend ? {{(IRQC_VW-IW){1'b0}}, win_idx} : IRQC_NONE;
    out_ce = (req_d != req_q) || (vec_d != vec_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= 1'b0;
      vec_q <= IRQC_NONE;
    end else if (out_ce) begin
      req_q <= req_d;
      vec_q <= vec_d;
    end
  end

  assign irq_req = req_q;
  assign irq_vec = vec_q;

endmodule

// File: rtl/cascade_irq_ctrl.sv
module cascade_irq_ctrl
  import irqc_pkg::*;
#(
  parameter int unsigned N_SRC = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_SRC-1:0]   src_lvl,
  input  logic               bus_we,
  input  logic [IRQC_AW-1:0] bus_addr,
  input  logic [N_SRC-1:0]   bus_wdata,
  output logic [N_SRC-1:0]   bus_rdata,
  output logic               irq_req,
  output logic [IRQC_VW-1:0] irq_vec
);

  localparam int unsigned IW = $clog2(N_SRC);

  logic             rst_sync_n;
  logic [N_SRC-1:0] pend_q;
  logic [N_SRC-1:0] ena_q;
  logic [N_SRC-1:0] mskd;
  logic             any_pend;
  logic [IW-1:0]    win_idx;

  irqc_rst_sync #(.STAGES(2)) rst_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  irqc_regs #(.N_SRC(N_SRC)) regs_i (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .src_lvl   (src_lvl),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .pend_q    (pend_q),
    .ena_q     (ena_q),
    .mskd      (mskd),
    .bus_rdata (bus_rdata)
  );

  irqc_prio #(.N_SRC(N_SRC)) prio_i (
    .mskd     (mskd),
    .any_pend (any_pend),
    .win_idx  (win_idx)
  );

  irqc_out #(.N_SRC(N_SRC)) out_i (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .any_pend (any_pend),
    .win_idx  (win_idx),
    .irq_req  (irq_req),
    .irq_vec  (irq_vec)
  );

endmodule

// File: rtl/irqc_chk.sv
module irqc_chk
  import irqc_pkg::*;
#(
  parameter int unsigned N_SRC = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic [N_SRC-1:0]   src_lvl,
  input logic               bus_we,
  input logic [IRQC_AW-1:0] bus_addr,
  input logic [N_SRC-1:0]   bus_wdata,
  input logic [N_SRC-1:0]   pend_q,
  input logic [N_SRC-1:0]   ena_q,
  input logic               irq_req,
  input logic [IRQC_VW-1:0] irq_vec
);

  AST_LEVEL_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (|src_lvl) |=> ((pend_q & $past(src_lvl)) == $past(src_lvl))); // R1

  AST_ENA_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == OFS_ENA) |=> (ena_q == $past(bus_wdata))); // R2

  AST_MSKD_RO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == OFS_MSKD) |=> $stable(ena_q)); // R3

  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == OFS_PEND) |=> ((pend_q & $past(bus_wdata & ~src_lvl)) == '0)); // R4

  AST_REQ_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq_req == $past(|(pend_q & ena_q)))); // R6

  AST_IDLE_VEC: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_req |-> (irq_vec == IRQC_NONE)); // R8

  AST_VEC_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (irq_vec < IRQC_VW'(N_SRC))); // R7

endmodule

bind cascade_irq_ctrl irqc_chk #(.N_SRC(N_SRC)) chk_i (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .src_lvl   (src_lvl),
  .bus_we    (bus_we),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .pend_q    (pend_q),
  .ena_q     (ena_q),
  .irq_req   (irq_req),
  .irq_vec   (irq_vec)
);

// File: tb/cascade_irq_ctrl_tb_top.sv
module cascade_irq_ctrl_tb_top;

  logic        clk;
  logic        rst_n;
  logic [31:0] src_lvl;
  logic        bus_we;
  logic [1:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        irq_req;
  logic [7:0]  irq_vec;

  int n_chk;
  int n_fail;
  bit done;

  typedef struct {
    logic [1:0]  addr;
    logic [31:0] rd;
    logic        req;
    logic [7:0]  vec;
    string       tag;
  } exp_t;

  exp_t sb[$];
  event chk_ev;

  cascade_irq_ctrl dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .src_lvl   (src_lvl),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq_req   (irq_req),
    .irq_vec   (irq_vec)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [31:0] sm(int n);
    return 32'h8000_0000 >> n;
  endfunction

  // drive one clock edge with the given inputs; returns at the following negedge
  task automatic drive(logic [31:0] s, logic we, logic [1:0] a, logic [31:0] d);
    @(negedge clk);
    src_lvl   = s;
    bus_we    = we;
    bus_addr  = a;
    bus_wdata = d;
    @(negedge clk);
    bus_we    = 1'b0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // driver side of the scoreboard: push the expectation, let the monitor compare
  task automatic chk(logic [1:0] a, logic [31:0] rd, logic rq, logic [7:0] v, string tag);
    exp_t it;
    bus_addr = a;
    #1;
    it.addr = a; it.rd = rd; it.req = rq; it.vec = v; it.tag = tag;
    sb.push_back(it);
    -> chk_ev;
    wait (sb.size() == 0);
  endtask

  // monitor side
  initial begin
    exp_t it;
    forever begin
      @(chk_ev);
      while (sb.size() > 0) begin
        it = sb.pop_front();
        n_chk++;
        if (bus_rdata !== it.rd || irq_req !== it.req || irq_vec !== it.vec) begin
          n_fail++;
          $display("FAIL %s: addr %0d rdata %h req %b vec %0d, expected rdata %h req %b vec %0d",
                   it.tag, it.addr, bus_rdata, irq_req, irq_vec, it.rd, it.req, it.vec);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    n_chk = 0; n_fail = 0; done = 1'b0;
    rst_n = 1'b0; src_lvl = '0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    idle(3);
    rst_n = 1'b1;
    idle(3);

    // R9 reset state
    chk(2'd0, 32'h0, 1'b0, 8'd255, "R9 pending");
    chk(2'd1, 32'h0, 1'b0, 8'd255, "R9 enable");

    // R1 level latches; disabled source stays hidden (R3)
    drive(sm(5), 1'b0, 2'd0, 32'h0);
    drive(32'h0, 1'b0, 2'd0, 32'h0);
    chk(2'd0, sm(5), 1'b0, 8'd255, "R1 latch");
    chk(2'd2, 32'h0, 1'b0, 8'd255, "R3 masked gated");

    // R2 enable all; R6 one-edge latency
    drive(32'h0, 1'b1, 2'd1, 32'hFFFF_FFFF);
    chk(2'd2, sm(5), 1'b0, 8'd255, "R6 latency");
    chk(2'd1, 32'hFFFF_FFFF, 1'b0, 8'd255, "R2 readback");
    idle(1);
    chk(2'd2, sm(5), 1'b1, 8'd5, "R6 R7 single");

    // R7 priority among several
    drive(sm(3) | sm(20), 1'b0, 2'd0, 32'h0);
    drive(32'h0, 1'b0, 2'd0, 32'h0);
    chk(2'd0, sm(3) | sm(5) | sm(20), 1'b1, 8'd3, "R7 lowest wins");

    // R4 partial clear, zeros untouched, clearing an idle bit harmless
    drive(32'h0, 1'b1, 2'd0, sm(3) | sm(9));
    chk(2'd0, sm(5) | sm(20), 1'b1, 8'd3, "R4 clear");
    idle(1);
    chk(2'd0, sm(5) | sm(20), 1'b1, 8'd5, "R4 R7 after clear");

    // R5 held level beats clear
    drive(sm(7), 1'b1, 2'd0, sm(7) | sm(5));
    chk(2'd0, sm(7) | sm(20), 1'b1, 8'd5, "R5 level wins");
    drive(32'h0, 1'b0, 2'd0, 32'h0);
    chk(2'd0, sm(7) | sm(20), 1'b1, 8'd7, "R5 R7 vector");

    // R3 write to masked offset ignored; unused offset reads zero
    drive(32'h0, 1'b1, 2'd2, 32'h0);
    chk(2'd1, 32'hFFFF_FFFF, 1'b1, 8'd7, "R3 enable kept");
    chk(2'd2, sm(7) | sm(20), 1'b1, 8'd7, "R3 pending kept");
    chk(2'd3, 32'h0, 1'b1, 8'd7, "R3 unused offset");

    // R7 boundaries: source 31 alone, then source 0
    drive(32'h0, 1'b1, 2'd0, 32'hFFFF_FFFF);
    drive(sm(31), 1'b0, 2'd0, 32'h0);
    chk(2'd0, 32'h0000_0001, 1'b0, 8'd255, "R8 after clear all");
    drive(32'h0, 1'b0, 2'd0, 32'h0);
    chk(2'd0, 32'h0000_0001, 1'b1, 8'd31, "R7 source 31");
    drive(sm(0), 1'b0, 2'd0, 32'h0);
    drive(32'h0, 1'b0, 2'd0, 32'h0);
    chk(2'd0, 32'h8000_0001, 1'b1, 8'd0, "R7 source 0");

    // R11 request held with no self-clear
    idle(6);
    chk(2'd2, 32'h8000_0001, 1'b1, 8'd0, "R11 held");

    // R2 partial enable changes winner
    drive(32'h0, 1'b1, 2'd1, 32'h0000_0001);
    idle(1);
    chk(2'd2, 32'h0000_0001, 1'b1, 8'd31, "R2 partial enable");

    // R10 init sequence
    drive(sm(12), 1'b0, 2'd0, 32'h0);
    drive(32'h0, 1'b1, 2'd1, 32'h0);
    drive(32'h0, 1'b1, 2'd0, 32'hFFFF_FFFF);
    idle(1);
    chk(2'd0, 32'h0, 1'b0, 8'd255, "R10 pending cleared");
    chk(2'd2, 32'h0, 1'b0, 8'd255, "R8 none pending");
    chk(2'd1, 32'h0, 1'b0, 8'd255, "R10 enable zero");

    // R5 again: held source survives repeated clears, then clears once low
    drive(32'h0, 1'b1, 2'd1, 32'hFFFF_FFFF);
    drive(sm(12), 1'b1, 2'd0, 32'hFFFF_FFFF);
    drive(sm(12), 1'b1, 2'd0, 32'hFFFF_FFFF);
    chk(2'd0, sm(12), 1'b1, 8'd12, "R5 held source");
    drive(32'h0, 1'b1, 2'd0, sm(12));
    chk(2'd0, 32'h0, 1'b1, 8'd12, "R4 cleared once low");
    idle(1);
    chk(2'd0, 32'h0, 1'b0, 8'd255, "R6 request drops");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule